// File: doc/BRIEF.md
# Maskable Host Interrupt Aggregator

This block gathers four interrupt sources of a host-attached buffer bridge and presents them as one active-high request line to the host. Two of the sources come from the data path (the outbound word has left the output buffer; an inbound word has landed in the input buffer). A third is a level line from an external test-access controller. The fourth is raised by the attached processor, either through its own host-interrupt pin or by writing 1 to a request bit of its own.

The processor source and the two buffer sources are sticky: once seen, they stay pending until the host writes 1 to their clear bit. The test-controller source is not stored. It mirrors its input, one clock late, and goes away only when the controller drops the line.

The host sees a 9-bit status word: the enables, the pending flags and the combined request. It writes an 8-bit control byte that has the same layout as the low status byte. The host can therefore write back a status byte it has just read. That clears every sticky source that was pending and keeps the enables as they were.

Top module: `host_irq_agg`

## Requirements
- R1: After reset, all enables and pending flags are 0, `statusWord` is 0 and `irqOut` is 0.
- R2: A control write loads the enables from `ctrlWrData[3:0]`: bit 0 is output-empty, bit 1 is input-full, bit 2 is test-controller and bit 3 is processor. The enables are visible in the next cycle in `statusWord[3:0]` and do not change when no write occurs.
- R3: An `evtOutEmpty` pulse sets pending flag `statusWord[4]`. A control write with bit 4 at 1 clears it. A control write with bit 4 at 0 leaves it set.
- R4: An `evtInFull` pulse sets pending flag `statusWord[5]`. A control write with bit 5 at 1 clears it.
- R5: Pending flag `statusWord[7]` is set by a `procIrqRaise` pulse, or by `procReqWrEn` while `procReqBit` is 1. A control write with bit 7 at 1 clears it.
- R6: `statusWord[6]` equals the `tstCtrlIrq` level of the previous cycle. Control bit 6 has no effect on it.
- R7: `irqOut` and `statusWord[8]` equal the OR, over the four sources, of each pending flag in bits 7:4 ANDed with its enable in bits 3:0.
- R8: If a set event and a write-one-to-clear of the same sticky flag fall in the same cycle, the flag is set afterwards.
- R9: Writing back a status byte read earlier clears every sticky flag that was 1 in that byte and keeps the enables it contained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Host control-byte write strobe |
| ctrlWrData | input | 8 | Control byte: enables in bits 3:0, clear bits in 7:4 (bit 6 unused) |
| evtOutEmpty | input | 1 | One-cycle pulse: the output buffer has emptied |
| evtInFull | input | 1 | One-cycle pulse: the input buffer has received a word |
| tstCtrlIrq | input | 1 | Level interrupt from the test-access controller |
| procIrqRaise | input | 1 | One-cycle pulse: the processor raised its host interrupt |
| procReqWrEn | input | 1 | Processor write strobe for its request bit |
| procReqBit | input | 1 | Value written to the processor request bit |
| statusWord | output | 9 | Read-only status: enables 3:0, pending 7:4, combined request 8 |
| irqOut | output | 1 | Combined active-high interrupt request |

## Verification
The assertions assume that the inputs are synchronous to `clk` and are held low while reset is active. The first cycle after reset then compares against known zero history. The bench drives every input at the falling edge from a single driver task, which meets both assumptions. Event inputs are pulses of one cycle, and the bench keeps the buffer and processor events one cycle wide so that each set and each clear can be seen in a cycle of its own. The bench raises events in the same cycle as a clear only in the R8 cases, where that collision is the point of the check.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int SRC_NUM  = 4;
  localparam int IDX_OBE  = 0;
  localparam int IDX_IBF  = 1;
  localparam int IDX_TST  = 2;
  localparam int IDX_PROC = 3;
  localparam int CTRL_W   = 2 * SRC_NUM;
  localparam int STAT_W   = CTRL_W + 1;

  typedef struct packed {
    logic               loadEn;
    logic [SRC_NUM-1:0] enVal;
    logic [SRC_NUM-1:0] clrMask;
    logic               procSet;
  } strobe_t;
endpackage

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import host_irq_pkg::*;
(
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              procReqWrEn,
  input  logic              procReqBit,
  output strobe_t           strobes
);
  always_comb begin
    strobes.loadEn  = ctrlWrEn;
    strobes.enVal   = ctrlWrData[SRC_NUM-1:0];
    strobes.clrMask = ctrlWrEn ? ctrlWrData[CTRL_W-1:SRC_NUM] : '0;
    strobes.procSet = procReqWrEn & procReqBit;
  end
endmodule

// File: rtl/host_irq_dp.sv
module host_irq_dp
  import host_irq_pkg::*;
#(
  parameter logic [SRC_NUM-1:0] LEVEL_MASK = 4'b0100
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [SRC_NUM-1:0] srcIn,
  output logic [SRC_NUM-1:0] enableQ,
  output logic [SRC_NUM-1:0] pendQ
);
  always_ff @(posedge clk) begin
    if (!rstN)                enableQ <= '0;
    else if (strobes.loadEn)  enableQ <= strobes.enVal;
  end

  for (genvar i = 0; i < SRC_NUM; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      always_ff @(posedge clk) begin
        if (!rstN) pendQ[i] <= 1'b0;
        else       pendQ[i] <= srcIn[i];
      end
    end else begin : g_sticky
      always_ff @(posedge clk) begin
        if (!rstN)          pendQ[i] <= 1'b0;
        else if (srcIn[i])  pendQ[i] <= 1'b1;
        else if (strobes.clrMask[i]) pendQ[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/host_irq_agg.sv
module host_irq_agg
  import host_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  input  logic              evtOutEmpty,
  input  logic              evtInFull,
  input  logic              tstCtrlIrq,
  input  logic              procIrqRaise,
  input  logic              procReqWrEn,
  input  logic              procReqBit,
  output logic [8:0]        statusWord,
  output logic              irqOut
);
  strobe_t            strobes;
  logic [SRC_NUM-1:0] srcIn;
  logic [SRC_NUM-1:0] enableQ;
  logic [SRC_NUM-1:0] pendQ;

  host_irq_ctrl u_ctrl (
    .ctrlWrEn    (ctrlWrEn),
    .ctrlWrData  (ctrlWrData),
    .procReqWrEn (procReqWrEn),
    .procReqBit  (procReqBit),
    .strobes     (strobes)
  );

  always_comb begin
    srcIn           = '0;
    srcIn[IDX_OBE]  = evtOutEmpty;
    srcIn[IDX_IBF]  = evtInFull;
    srcIn[IDX_TST]  = tstCtrlIrq;
    srcIn[IDX_PROC] = procIrqRaise | strobes.procSet;
  end

  host_irq_dp #(.LEVEL_MASK(4'b0100)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcIn   (srcIn),
    .enableQ (enableQ),
    .pendQ   (pendQ)
  );

  assign irqOut     = |(pendQ & enableQ);
  assign statusWord = {irqOut, pendQ, enableQ};
endmodule

// File: rtl/host_irq_agg_chk.sv
module host_irq_agg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWrEn,
  input logic [7:0] ctrlWrData,
  input logic       evtOutEmpty,
  input logic       tstCtrlIrq,
  input logic       procReqWrEn,
  input logic       procReqBit,
  input logic [8:0] statusWord,
  input logic       irqOut
);
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> statusWord[3:0] == $past(ctrlWrData[3:0])); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrEn |=> $stable(statusWord[3:0])); // R2
  AST_OBE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[4] && !evtOutEmpty) |=> !statusWord[4]); // R3
  AST_PROC_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (procReqWrEn && procReqBit) |=> statusWord[7]); // R5
  AST_TST_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusWord[6] == $past(tstCtrlIrq)); // R6
  AST_IRQ_COMBINE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(statusWord[7:4] & statusWord[3:0])); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtOutEmpty |=> statusWord[4]); // R8
endmodule

bind host_irq_agg host_irq_agg_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWrEn    (ctrlWrEn),
  .ctrlWrData  (ctrlWrData),
  .evtOutEmpty (evtOutEmpty),
  .tstCtrlIrq  (tstCtrlIrq),
  .procReqWrEn (procReqWrEn),
  .procReqBit  (procReqBit),
  .statusWord  (statusWord),
  .irqOut      (irqOut)
);

// File: tb/host_irq_agg_tb_top.sv
module host_irq_agg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic       evtOutEmpty = 1'b0;
  logic       evtInFull = 1'b0;
  logic       tstCtrlIrq = 1'b0;
  logic       procIrqRaise = 1'b0;
  logic       procReqWrEn = 1'b0;
  logic       procReqBit = 1'b0;
  logic [8:0] statusWord;
  logic       irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [8:0] expQ[$];
  string      tagQ[$];

  logic [3:0] mEn = '0;
  logic [3:0] mPend = '0;

  always #4 clk = ~clk;

  host_irq_agg dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .evtOutEmpty(evtOutEmpty), .evtInFull(evtInFull), .tstCtrlIrq(tstCtrlIrq),
    .procIrqRaise(procIrqRaise), .procReqWrEn(procReqWrEn), .procReqBit(procReqBit),
    .statusWord(statusWord), .irqOut(irqOut)
  );

  function automatic logic [8:0] modelStatus();
    return {|(mPend & mEn), mPend, mEn};
  endfunction

  task automatic step(input logic wr, input logic [7:0] d, input logic oe,
                      input logic inf, input logic tst, input logic praise,
                      input logic preq, input string tag);
    logic [3:0] setV;
    logic [3:0] clrV;
    @(negedge clk);
    ctrlWrEn = wr; ctrlWrData = d; evtOutEmpty = oe; evtInFull = inf;
    tstCtrlIrq = tst; procIrqRaise = praise; procReqWrEn = preq; procReqBit = preq;
    setV = {praise | preq, 1'b0, inf, oe};
    clrV = wr ? {d[7], 1'b0, d[5], d[4]} : 4'b0;
    mPend = {(setV[3] | (mPend[3] & ~clrV[3])), tst,
             (setV[1] | (mPend[1] & ~clrV[1])),
             (setV[0] | (mPend[0] & ~clrV[0]))};
    if (wr) mEn = d[3:0];
    expQ.push_back(modelStatus());
    tagQ.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 1'b0, 1'b0, tstCtrlIrq, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare one cycle's result after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (statusWord !== e || irqOut !== e[8]) begin
          failures++;
          $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                   t, statusWord, irqOut, e, e[8]);
        end
      end
    end
  end

  initial begin
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (statusWord !== 9'h000 || irqOut !== 1'b0) begin
      failures++;
      $display("FAIL R1: status=%h irq=%b expected status=000 irq=0", statusWord, irqOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    idle("R1");
    step(1, 8'h0F, 0, 0, 0, 0, 0, "R2");
    idle("R2");
    step(0, 8'h00, 1, 0, 0, 0, 0, "R3");
    step(1, 8'h0F, 0, 0, 0, 0, 0, "R3");
    step(1, 8'h1F, 0, 0, 0, 0, 0, "R3");
    step(0, 8'h00, 0, 1, 0, 0, 0, "R4");
    step(1, 8'h2F, 0, 0, 0, 0, 0, "R4");
    step(0, 8'h00, 0, 0, 0, 1, 0, "R5");
    step(1, 8'h8F, 0, 0, 0, 0, 0, "R5");
    step(0, 8'h00, 0, 0, 0, 0, 1, "R5");
    step(1, 8'h8F, 0, 0, 0, 0, 0, "R5");
    step(0, 8'h00, 0, 0, 1, 0, 0, "R6");
    step(1, 8'h4F, 0, 0, 1, 0, 0, "R6");
    step(1, 8'hCB, 0, 0, 1, 0, 0, "R6");
    step(1, 8'h0F, 0, 0, 0, 0, 0, "R6");
    step(1, 8'h00, 1, 0, 0, 0, 0, "R7");
    step(1, 8'h01, 0, 0, 0, 0, 0, "R7");
    step(1, 8'h02, 0, 0, 0, 0, 0, "R7");
    step(1, 8'h04, 0, 0, 1, 0, 0, "R7");
    step(1, 8'h0F, 0, 0, 0, 0, 0, "R7");
    step(1, 8'h1F, 1, 0, 0, 0, 0, "R8");
    step(1, 8'hBF, 0, 1, 0, 1, 0, "R8");
    step(1, 8'h0A, 1, 1, 0, 1, 0, "R9");
    idle("R9");
    rb = modelStatus();
    step(1, rb[7:0], 0, 0, 0, 0, 0, "R9");
    idle("R9");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule